// File: doc/BRIEF.md
# Two-Wire Bus Frame Observer

This block watches the clock and data lines of an open-drain two-wire serial bus from the side, using a much faster system clock to oversample both lines. It never drives either line. From the oversampled levels it finds the frame boundaries: a frame opens when data falls while the bus clock is high, and closes when data rises while the bus clock is high. A second opening seen before any closing is reported as a repeated start, kept apart from a plain start. A busy flag runs from an opening to the next closing.

Inside a frame, every rising edge of the bus clock samples one bit. Eight bits, most significant first, make a byte, and the ninth bit is the acknowledge. After the ninth rising edge the block pulses a byte-valid strobe and presents the byte, the acknowledge value, and whether the byte was the first one of its frame. The first byte is the target address: its upper seven bits are latched as the address and its lowest bit as the direction. Any frame boundary throws away a byte that is not yet complete.

Typical use is a protocol monitor or trace feeder placed next to a bus, with the event strobes and the byte fields logged by the system clock domain.

Top module: `i2c_frame_monitor`

## Requirements
- R1: A fall of SDA while SCL is high, seen while the bus is free, gives a one-cycle `start_o` pulse.
- R2: A rise of SDA while SCL is high gives a one-cycle `stop_o` pulse and makes the bus free.
- R3: A fall of SDA while SCL is high, seen while the bus is busy, gives a one-cycle `rstart_o` pulse and no `start_o` pulse.
- R4: `busy_o` is 1 from the cycle of a start or repeated start pulse up to the cycle of the next stop pulse, where it becomes 0.
- R5: While busy, each SCL rising edge samples SDA. After 8 samples the byte, with the first sample in bit 7, appears on `byte_o` together with a one-cycle `byte_valid_o` pulse on the ninth SCL rising edge.
- R6: With each `byte_valid_o` pulse, `ack_o` is 1 when SDA was low on the ninth rising edge (acknowledged) and 0 when it was high.
- R7: `addr_byte_o` is 1 with a `byte_valid_o` pulse only for the first byte after a start or repeated start. That byte's bits 7..1 are latched into `addr_o` and its bit 0 into `rw_o` (1 = read). Both hold their value until the next address byte.
- R8: A start, repeated start or stop clears the bit count, so the bits of an incomplete byte never produce a `byte_valid_o` pulse. SCL edges while the bus is free are ignored.
- R9: Each line passes through two synchronizer flops, so an event pulse appears exactly three system clocks after the line change that causes it.
- R10: While `rst_n` is low at a rising clock edge, all pulses, `busy_o`, `byte_o`, `ack_o`, `addr_byte_o`, `addr_o` and `rw_o` go to 0, and both lines are taken to be idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Bus data line level (asynchronous) |
| start_o | output | 1 | Start pulse, bus was free |
| rstart_o | output | 1 | Repeated start pulse, bus was busy |
| stop_o | output | 1 | Stop pulse |
| busy_o | output | 1 | Bus busy flag |
| byte_valid_o | output | 1 | One-cycle strobe: byte and acknowledge complete |
| byte_o | output | 8 | Last complete byte, first bit in bit 7 |
| ack_o | output | 1 | 1 = last byte acknowledged |
| addr_byte_o | output | 1 | Last byte was the first byte of its frame |
| addr_o | output | 7 | Latched target address |
| rw_o | output | 1 | Latched direction, 1 = read |

## Verification
A wrong bit count or a stale first-byte flag shows up at the ninth SCL edge of the affected byte: `byte_valid_o` comes early or late, or `addr_byte_o` has the wrong value. A wrong busy state shows as soon as the next frame boundary, because a start is then reported as a repeated start or the other way round. Every output is compared each cycle against a behavioural model, so these faults are caught within one byte slot of their cause. The fixed three-cycle delay through the synchronizers is checked directly on the first start.

// File: rtl/i2cmon_pkg.sv
// Package: shared types for the two-wire frame observer.
// Assumes nothing beyond the enum being used by the detector and the frame tracker.
package i2cmon_pkg;
    typedef enum logic [1:0] {
        COND_NONE  = 2'd0,
        COND_START = 2'd1,
        COND_STOP  = 2'd2
    } cond_e;
endpackage

// File: rtl/i2cmon_sync.sv
// Module: i2cmon_sync
// Carries one asynchronous line level into the clk domain through STAGES flops.
// Assumes the idle level of the line is high; reset loads ones.
module i2cmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the line level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cmon_cond.sv
// Module: i2cmon_cond
// Compares the synchronized lines with their previous values and reports
// frame boundaries and SCL rising edges. Assumes lines idle high after reset.
module i2cmon_cond
    import i2cmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  scl,
    input  logic  sda,
    output cond_e cond,
    output logic  scl_rise
);
    logic scl_prev, sda_prev;
    logic scl_held;

    // Remember the previous synchronized levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl;
            sda_prev <= sda;
        end
    end

    // Classify the current sample: SDA edges while SCL stays high are boundaries.
    always_comb begin
        scl_held = scl && scl_prev;
        cond     = COND_NONE;
        if (scl_held && sda_prev && !sda)      cond = COND_START;
        else if (scl_held && !sda_prev && sda) cond = COND_STOP;
        scl_rise = scl && !scl_prev;
    end
endmodule

// File: rtl/i2cmon_frame.sv
// Module: i2cmon_frame
// Tracks bus busy state, counts bit slots, assembles bytes and the acknowledge,
// and latches the address byte. Assumes boundary and edge inputs never coincide.
module i2cmon_frame
    import i2cmon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cond_e             cond,
    input  logic              scl_rise,
    input  logic              sda,
    output logic              start_o,
    output logic              rstart_o,
    output logic              stop_o,
    output logic              busy_o,
    output logic              byte_valid_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              ack_o,
    output logic              addr_byte_o,
    output logic [DATA_W-2:0] addr_o,
    output logic              rw_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic              first_pending;

    // Frame state, byte assembly and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o       <= 1'b0;
            rstart_o      <= 1'b0;
            stop_o        <= 1'b0;
            busy_o        <= 1'b0;
            byte_valid_o  <= 1'b0;
            byte_o        <= '0;
            ack_o         <= 1'b0;
            addr_byte_o   <= 1'b0;
            addr_o        <= '0;
            rw_o          <= 1'b0;
            bit_cnt       <= '0;
            shreg         <= '0;
            first_pending <= 1'b0;
        end else begin
            start_o      <= 1'b0;
            rstart_o     <= 1'b0;
            stop_o       <= 1'b0;
            byte_valid_o <= 1'b0;
            case (cond)
                COND_START: begin
                    if (busy_o) rstart_o <= 1'b1;
                    else        start_o  <= 1'b1;
                    busy_o        <= 1'b1;
                    bit_cnt       <= '0;
                    first_pending <= 1'b1;
                end
                COND_STOP: begin
                    stop_o  <= 1'b1;
                    busy_o  <= 1'b0;
                    bit_cnt <= '0;
                end
                default: begin
                    if (scl_rise && busy_o) begin
                        if (bit_cnt == ACK_SLOT) begin
                            byte_valid_o  <= 1'b1;
                            byte_o        <= shreg;
                            ack_o         <= !sda;
                            addr_byte_o   <= first_pending;
                            if (first_pending) begin
                                addr_o <= shreg[DATA_W-1:1];
                                rw_o   <= shreg[0];
                            end
                            first_pending <= 1'b0;
                            bit_cnt       <= '0;
                        end else begin
                            shreg   <= {shreg[DATA_W-2:0], sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_frame_monitor.sv
// Module: i2c_frame_monitor (top)
// Passive observer of a two-wire bus: synchronizes both lines, finds frame
// boundaries and decodes bytes. Never drives the bus. Assumes clk is at least
// several times faster than SCL so every SCL phase is sampled.
module i2c_frame_monitor
    import i2cmon_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              start_o,
    output logic              rstart_o,
    output logic              stop_o,
    output logic              busy_o,
    output logic              byte_valid_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              ack_o,
    output logic              addr_byte_o,
    output logic [DATA_W-2:0] addr_o,
    output logic              rw_o
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] syn_lines;
    cond_e                cond;
    logic                 scl_rise;

    assign raw_lines = {scl_i, sda_i};

    // One synchronizer per line.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
        i2cmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_lines[g]),
            .q     (syn_lines[g])
        );
    end

    i2cmon_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (syn_lines[1]),
        .sda      (syn_lines[0]),
        .cond     (cond),
        .scl_rise (scl_rise)
    );

    i2cmon_frame #(.DATA_W(DATA_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .cond         (cond),
        .scl_rise     (scl_rise),
        .sda          (syn_lines[0]),
        .start_o      (start_o),
        .rstart_o     (rstart_o),
        .stop_o       (stop_o),
        .busy_o       (busy_o),
        .byte_valid_o (byte_valid_o),
        .byte_o       (byte_o),
        .ack_o        (ack_o),
        .addr_byte_o  (addr_byte_o),
        .addr_o       (addr_o),
        .rw_o         (rw_o)
    );
endmodule

// File: rtl/i2cmon_checker.sv
// Module: i2cmon_checker
// Temporal properties of the observer's ports, bound into every instance.
module i2cmon_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_o,
    input logic              rstart_o,
    input logic              stop_o,
    input logic              busy_o,
    input logic              byte_valid_o,
    input logic              addr_byte_o,
    input logic [DATA_W-2:0] addr_o,
    input logic              rw_o
);
    // R1: a plain start only comes from a free bus and leaves it busy.
    a_r1_start_from_free: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (!$past(busy_o) && busy_o));

    // R2: a stop leaves the bus free.
    a_r2_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !busy_o);

    // R3: a repeated start only comes from a busy bus.
    a_r3_rstart_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_o |-> $past(busy_o));

    // R4: busy only rises with a start pulse and only falls with a stop pulse.
    a_r4_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> start_o);
    a_r4_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> stop_o);

    // R5: events are mutually exclusive, and bytes only complete inside a frame.
    a_r5_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, rstart_o, stop_o, byte_valid_o}));
    a_r5_byte_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> $past(busy_o));

    // R7: the latched address and direction change only with an address byte.
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid_o && addr_byte_o) |-> ($stable(addr_o) && $stable(rw_o)));
endmodule

bind i2c_frame_monitor i2cmon_checker #(.DATA_W(DATA_W)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_o      (start_o),
    .rstart_o     (rstart_o),
    .stop_o       (stop_o),
    .busy_o       (busy_o),
    .byte_valid_o (byte_valid_o),
    .addr_byte_o  (addr_byte_o),
    .addr_o       (addr_o),
    .rw_o         (rw_o)
);

// File: tb/i2c_frame_monitor_bench.sv
// Bench: drives bus frames and compares every output each cycle with a
// behavioural model that works from a history queue of sampled line levels.
module i2c_frame_monitor_bench;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_i = 1'b1;
    logic       sda_i = 1'b1;
    logic       start_o, rstart_o, stop_o, busy_o, byte_valid_o;
    logic [7:0] byte_o;
    logic       ack_o, addr_byte_o;
    logic [6:0] addr_o;
    logic       rw_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;

    always #2 clk = ~clk;

    i2c_frame_monitor u_i2c_frame_monitor (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .start_o(start_o), .rstart_o(rstart_o), .stop_o(stop_o), .busy_o(busy_o),
        .byte_valid_o(byte_valid_o), .byte_o(byte_o), .ack_o(ack_o),
        .addr_byte_o(addr_byte_o), .addr_o(addr_o), .rw_o(rw_o)
    );

    // Reference model state.
    logic [1:0] hq[$] = '{2'b11, 2'b11, 2'b11, 2'b11};
    bit m_start, m_rstart, m_stop, m_busy, m_bv, m_ack, m_ab, m_rw, m_first;
    int m_cnt, m_sh, m_byte, m_addr;
    int bytes_seen[$];

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model update on each rising edge from the delayed line history.
    always @(posedge clk) begin
        logic [1:0] p, c;
        hq.push_back(rst_n ? {scl_i, sda_i} : 2'b11);
        void'(hq.pop_front());
        p = hq[0];
        c = hq[1];
        m_start = 0; m_rstart = 0; m_stop = 0; m_bv = 0;
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_sh = 0; m_byte = 0; m_ack = 0;
            m_ab = 0; m_addr = 0; m_rw = 0; m_first = 0;
        end else if (p[1] && c[1] && p[0] && !c[0]) begin
            if (m_busy) m_rstart = 1; else m_start = 1;
            m_busy = 1; m_cnt = 0; m_first = 1;
        end else if (p[1] && c[1] && !p[0] && c[0]) begin
            m_stop = 1; m_busy = 0; m_cnt = 0;
        end else if (!p[1] && c[1] && m_busy) begin
            if (m_cnt == 8) begin
                m_bv = 1; m_byte = m_sh; m_ack = !c[0]; m_ab = m_first;
                if (m_first) begin m_addr = m_sh / 2; m_rw = m_sh[0]; end
                m_first = 0; m_cnt = 0;
            end else begin
                m_sh = ((m_sh << 1) | int'(c[0])) & 255;
                m_cnt++;
            end
        end
    end

    // Compare every output with the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check("R1", "start_o", start_o, m_start);
            check("R2", "stop_o", stop_o, m_stop);
            check("R3", "rstart_o", rstart_o, m_rstart);
            check("R4", "busy_o", busy_o, m_busy);
            check("R5", "byte_valid_o", byte_valid_o, m_bv);
            check("R5", "byte_o", byte_o, m_byte);
            check("R6", "ack_o", ack_o, m_ack);
            check("R7", "addr_byte_o", addr_byte_o, m_ab);
            check("R7", "addr_o", addr_o, m_addr);
            check("R7", "rw_o", rw_o, m_rw);
            if (byte_valid_o) bytes_seen.push_back(int'(byte_o));
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input bit b);
        sda_i = b;  wait_n(HALF);
        scl_i = 1;  wait_n(HALF);
        scl_i = 0;  wait_n(2);
    endtask

    task automatic put_byte(input logic [7:0] v, input bit nack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        put_bit(nack);
    endtask

    task automatic put_start;
        sda_i = 1; scl_i = 1; wait_n(HALF);
        sda_i = 0; wait_n(HALF);
        scl_i = 0; wait_n(2);
    endtask

    task automatic put_rstart;
        sda_i = 1; wait_n(HALF);
        scl_i = 1; wait_n(HALF);
        sda_i = 0; wait_n(HALF);
        scl_i = 0; wait_n(2);
    endtask

    task automatic put_stop;
        sda_i = 0; wait_n(HALF);
        scl_i = 1; wait_n(HALF);
        sda_i = 1; wait_n(HALF);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        wait_n(3);
        rst_n = 1;
        wait_n(1);
        // R10: reset state at the ports.
        check("R10", "busy after reset", busy_o, 0);
        check("R10", "byte after reset", byte_o, 0);
        check("R10", "addr after reset", addr_o, 0);
        check("R10", "pulses after reset", {start_o, rstart_o, stop_o, byte_valid_o}, 0);
        cmp_en = 1;
        wait_n(4);

        // R9: start pulse exactly three clocks after SDA falls.
        sda_i = 0;
        wait_n(1); check("R9", "start at +1", start_o, 0);
        wait_n(1); check("R9", "start at +2", start_o, 0);
        wait_n(1); check("R9", "start at +3", start_o, 1);
        wait_n(HALF);
        scl_i = 0; wait_n(2);

        put_byte(8'hA5, 0);            // address, read, acknowledged
        put_byte(8'h3C, 1);            // data, not acknowledged
        check("R6", "ack of 0x3C", ack_o, 0);
        put_rstart();
        put_byte(8'h50, 0);            // address, write
        check("R7", "rw after 0x50", rw_o, 0);
        check("R7", "addr after 0x50", addr_o, 8'h28);
        put_bit(1); put_bit(0); put_bit(1);   // partial byte, R8
        put_stop();
        wait_n(10);
        put_start();
        put_byte(8'hFF, 0);
        put_stop();
        wait_n(10);

        // R8: SCL pulses on a free bus are ignored.
        put_bit(0); put_bit(1);
        wait_n(4);

        // R10: reset in the middle of a byte.
        put_start();
        put_bit(1); put_bit(1); put_bit(0); put_bit(1);
        rst_n = 0; wait_n(2);
        check("R10", "busy in reset", busy_o, 0);
        rst_n = 1;
        put_bit(0); put_bit(0); put_bit(0); put_bit(0); put_bit(0);
        put_stop();
        wait_n(10);

        // R5/R8: exactly the four whole bytes were reported.
        check("R8", "byte count", bytes_seen.size(), 4);
        if (bytes_seen.size() == 4) begin
            check("R5", "byte 0", bytes_seen[0], 8'hA5);
            check("R5", "byte 1", bytes_seen[1], 8'h3C);
            check("R5", "byte 2", bytes_seen[2], 8'h50);
            check("R5", "byte 3", bytes_seen[3], 8'hFF);
        end
        done = 1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            finish_run();
        end
    end
endmodule